// File: doc/BRIEF.md
# Voice Core Mode Control Register

This block is one byte-wide control register that a host writes to steer a voice-processing core. It also holds a small set of byte registers that together form a 16-bit memory address and a 16-bit data word. When the host sets the write-go bit while the core is in initialization, the block issues a single write strobe toward internal data memory. When the core is not in initialization, the request is discarded.

Two bypass controls do not follow the host write directly. One bypasses the gain pads around the echo path and the other bypasses the transmit slope filter. Each is the OR of a register bit and an external pin, and it is sampled only on the rising edge of the frame sync strobe. Noise-canceler selection forms a 2-bit code. Code 00 puts the noise canceler in through mode, and this choice follows the register and the pin at all times. The attenuation code is copied while initialization is active and is frozen once initialization ends. It stays frozen until the next reset.

Top module: `mcr_top`

## Requirements
- R1: After synchronous reset, mem_we, pad_bypass, slope_bypass, nc_att, mem_addr, mem_wdata and ctrl_rdata are all 0, and nc_through is 1.
- R2: Host select 1 loads mem_addr[15:8], select 2 loads mem_addr[7:0], select 3 loads mem_wdata[15:8] and select 4 loads mem_wdata[7:0]. Each takes effect on the clock edge of the host write.
- R3: A host write to select 0 with bit 0 = 1 while init_mode is 1 makes mem_we high for exactly the one cycle that follows the write edge, and mem_addr and mem_wdata hold the stored bytes during that cycle.
- R4: Control bit 0 (write-go) reads back as 1 in the cycle after an accepted request and clears itself to 0 one cycle later.
- R5: A write-go request made while init_mode is 0 is ignored. mem_we stays 0 and bit 0 reads back as 0.
- R6: pad_bypass changes only on a clock edge where frame_sync is 1 and it was 0 on the previous edge. On such an edge it loads control bit 1 OR pad_pin.
- R7: slope_bypass follows the same frame_sync rule with control bit 2 OR slope_pin. The value 0 means the filter is active and 1 means through mode.
- R8: The live noise code is {bit 4, bit 3 OR nc_pin}. nc_through is 1 exactly when that code is 00, in both initialization and normal operation.
- R9: While init_mode is 1, nc_att loads the live noise code on every edge. While init_mode is 0, nc_att holds its value until reset.
- R10: Control bits 7:5 are reserved. They always read back as 0, and any data written to them is discarded.
- R11: ctrl_rdata bits 4:1 return the bits 4:1 of the last write to select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable |
| host_sel | input | 3 | Host register select: 0 control, 1-2 address bytes, 3-4 data bytes |
| host_wdata | input | 8 | Host write data |
| ctrl_rdata | output | 8 | Control register readback |
| init_mode | input | 1 | Core is in initialization |
| frame_sync | input | 1 | Frame sync strobe |
| pad_pin | input | 1 | External pad-bypass pin |
| slope_pin | input | 1 | External slope-filter-bypass pin |
| nc_pin | input | 1 | External noise-select pin, ORed into code bit 0 |
| pad_bypass | output | 1 | Sampled pad-bypass control |
| slope_bypass | output | 1 | Sampled slope-filter-bypass control |
| nc_through | output | 1 | Noise canceler in through mode |
| nc_att | output | 2 | Attenuation code frozen at the end of initialization |
| mem_we | output | 1 | Single-cycle memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 16 | Memory write data |

## Verification
The bench builds the block with its default 16-bit address and 16-bit data. With these values the two address bytes and the two data bytes each map onto a full output word, and a sweep of computed patterns covers every byte lane. The four control bits and the three pins are few enough to sweep exhaustively. Every combination of bypass bit and pin is tried against the frame_sync edge, and every noise code with both pin values is tried in initialization and again after the code is frozen.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int HOST_SEL_W = 3;
    localparam int BYTE_W     = 8;

    // Stored control fields, bits 4:1 of the control byte
    typedef struct packed {
        logic nc_b;
        logic nc_a;
        logic slope;
        logic pad;
    } ctrl_t;

    typedef enum logic [1:0] {
        NC_THROUGH = 2'b00,
        NC_LOW     = 2'b01,
        NC_MID     = 2'b10,
        NC_HIGH    = 2'b11
    } nc_code_t;

    function automatic nc_code_t nc_code(input logic b, input logic a, input logic pin);
        return nc_code_t'({b, a | pin});
    endfunction

    function automatic logic [7:0] ctrl_word(input ctrl_t c, input logic go);
        return {3'b000, c.nc_b, c.nc_a, c.slope, c.pad, go};
    endfunction

endpackage

// File: rtl/mcr_regfile.sv
module mcr_regfile
    import mcr_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int MEM_DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [HOST_SEL_W-1:0] host_sel,
    input  logic [BYTE_W-1:0]     host_wdata,
    input  logic                  init_mode,
    output ctrl_t                 ctrl_o,
    output logic                  go_o,
    output logic [MEM_AW-1:0]     mem_addr,
    output logic [MEM_DW-1:0]     mem_wdata
);

    localparam int AB = MEM_AW / BYTE_W;
    localparam int DB = MEM_DW / BYTE_W;

    ctrl_t ctrl_q;
    logic  go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (host_we && host_sel == '0) begin
                ctrl_q <= ctrl_t'(host_wdata[4:1]);
                go_q   <= host_wdata[0] & init_mode;
            end
        end
    end

    genvar k;
    generate
        for (k = 0; k < AB; k++) begin : g_addr
            logic [BYTE_W-1:0] b_q;
            always_ff @(posedge clk) begin
                if (rst)
                    b_q <= '0;
                else if (host_we && host_sel == HOST_SEL_W'(1 + k))
                    b_q <= host_wdata;
            end
            assign mem_addr[MEM_AW-1-BYTE_W*k -: BYTE_W] = b_q;
        end
        for (k = 0; k < DB; k++) begin : g_data
            logic [BYTE_W-1:0] b_q;
            always_ff @(posedge clk) begin
                if (rst)
                    b_q <= '0;
                else if (host_we && host_sel == HOST_SEL_W'(1 + AB + k))
                    b_q <= host_wdata;
            end
            assign mem_wdata[MEM_DW-1-BYTE_W*k -: BYTE_W] = b_q;
        end
    endgenerate

    assign ctrl_o = ctrl_q;
    assign go_o   = go_q;

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        go_q |=> !go_q);
    // R5
    strobe_init_only_chk: assert property (@(posedge clk) disable iff (rst)
        go_q |-> $past(init_mode));

endmodule

// File: rtl/mcr_sync_sample.sv
module mcr_sync_sample #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_in,
    input  logic [N-1:0] bits_in,
    input  logic [N-1:0] pins_in,
    output logic [N-1:0] q_out
);

    logic         sync_d;
    logic         sync_rise;
    logic [N-1:0] q_r;

    assign sync_rise = sync_in & ~sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= 1'b0;
            q_r    <= '0;
        end else begin
            sync_d <= sync_in;
            if (sync_rise)
                q_r <= bits_in | pins_in;
        end
    end

    assign q_out = q_r;

    // R6 R7
    bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_rise |=> $stable(q_r));

endmodule

// File: rtl/mcr_nc_select.sv
module mcr_nc_select
    import mcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     init_mode,
    input  logic     sel_b,
    input  logic     sel_a,
    input  logic     sel_pin,
    output logic     nc_through,
    output nc_code_t nc_att
);

    nc_code_t live;
    nc_code_t att_q;

    assign live = nc_code(sel_b, sel_a, sel_pin);

    always_ff @(posedge clk) begin
        if (rst)
            att_q <= NC_THROUGH;
        else if (init_mode)
            att_q <= live;
    end

    assign nc_through = (live == NC_THROUGH);
    assign nc_att     = att_q;

    // R9
    att_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !init_mode |=> $stable(att_q));

endmodule

// File: rtl/mcr_top.sv
module mcr_top
    import mcr_pkg::*;
#(
    parameter int MEM_AW = 16,
    parameter int MEM_DW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [HOST_SEL_W-1:0] host_sel,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            ctrl_rdata,
    input  logic                  init_mode,
    input  logic                  frame_sync,
    input  logic                  pad_pin,
    input  logic                  slope_pin,
    input  logic                  nc_pin,
    output logic                  pad_bypass,
    output logic                  slope_bypass,
    output logic                  nc_through,
    output logic [1:0]            nc_att,
    output logic                  mem_we,
    output logic [MEM_AW-1:0]     mem_addr,
    output logic [MEM_DW-1:0]     mem_wdata
);

    ctrl_t    ctrl;
    logic     go;
    logic [1:0] byp_q;
    nc_code_t att;

    mcr_regfile #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .init_mode  (init_mode),
        .ctrl_o     (ctrl),
        .go_o       (go),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    mcr_sync_sample #(.N(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sync_in (frame_sync),
        .bits_in ({ctrl.slope, ctrl.pad}),
        .pins_in ({slope_pin, pad_pin}),
        .q_out   (byp_q)
    );

    mcr_nc_select u_nc (
        .clk        (clk),
        .rst        (rst),
        .init_mode  (init_mode),
        .sel_b      (ctrl.nc_b),
        .sel_a      (ctrl.nc_a),
        .sel_pin    (nc_pin),
        .nc_through (nc_through),
        .nc_att     (att)
    );

    assign pad_bypass   = byp_q[0];
    assign slope_bypass = byp_q[1];
    assign nc_att       = att;
    assign mem_we       = go;
    assign ctrl_rdata   = ctrl_word(ctrl, go);

    // R4
    go_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[0] |=> !ctrl_rdata[0]);

endmodule

// File: tb/tb_mcr_top.sv
`timescale 1ns/1ps
module tb_mcr_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_we;
    logic [2:0]  host_sel;
    logic [7:0]  host_wdata;
    logic [7:0]  ctrl_rdata;
    logic        init_mode, frame_sync, pad_pin, slope_pin, nc_pin;
    logic        pad_bypass, slope_bypass, nc_through;
    logic [1:0]  nc_att;
    logic        mem_we;
    logic [15:0] mem_addr, mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mcr_top dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .ctrl_rdata(ctrl_rdata), .init_mode(init_mode),
        .frame_sync(frame_sync), .pad_pin(pad_pin), .slope_pin(slope_pin),
        .nc_pin(nc_pin), .pad_bypass(pad_bypass), .slope_bypass(slope_bypass),
        .nc_through(nc_through), .nc_att(nc_att), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] cfg;
        logic pad_exp, slope_exp;
        host_we = 0; host_sel = 0; host_wdata = 0;
        init_mode = 1; frame_sync = 0; pad_pin = 0; slope_pin = 0; nc_pin = 0;
        do_reset();

        // R1 reset state
        chk("R1 mem_we", mem_we, 0);
        chk("R1 pad", pad_bypass, 0);
        chk("R1 slope", slope_bypass, 0);
        chk("R1 nc_through", nc_through, 1);
        chk("R1 nc_att", nc_att, 0);
        chk("R1 rdata", ctrl_rdata, 0);
        chk("R1 addr", mem_addr, 0);
        chk("R1 wdata", mem_wdata, 0);

        // R2 R3 R4 accepted memory writes
        cfg = 4'b0000;
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a, d;
            a = 16'(i * 9319 + 257);
            d = ~a ^ 16'(i << 9);
            host_wr(3'd1, a[15:8]);
            host_wr(3'd2, a[7:0]);
            host_wr(3'd3, d[15:8]);
            host_wr(3'd4, d[7:0]);
            chk("R2 addr", mem_addr, a);
            chk("R2 wdata", mem_wdata, d);
            host_wr(3'd0, {3'b000, cfg, 1'b1});
            chk("R3 strobe", mem_we, 1);
            chk("R3 addr", mem_addr, a);
            chk("R3 data", mem_wdata, d);
            chk("R4 go set", ctrl_rdata[0], 1);
            @(negedge clk);
            chk("R3 strobe drop", mem_we, 0);
            chk("R4 go clear", ctrl_rdata[0], 0);
        end

        // R5 request outside initialization
        init_mode = 0;
        host_wr(3'd0, 8'h01);
        chk("R5 no strobe", mem_we, 0);
        chk("R5 go zero", ctrl_rdata[0], 0);
        @(negedge clk);
        chk("R5 no strobe later", mem_we, 0);
        init_mode = 1;

        // R10 R11 reserved and stored bits
        host_wr(3'd0, 8'hFE);
        chk("R10 reserved", ctrl_rdata[7:5], 0);
        chk("R11 stored", ctrl_rdata[4:1], 4'hF);
        chk("R11 full", ctrl_rdata, 8'h1E);
        host_wr(3'd0, 8'hA4);
        chk("R10 reserved2", ctrl_rdata[7:5], 0);
        chk("R11 stored2", ctrl_rdata[4:1], 4'h2);

        // R6 R7 bypass sampling sweep
        host_wr(3'd0, 8'h00);
        frame_sync = 1; @(negedge clk); frame_sync = 0; @(negedge clk);
        pad_exp = 0; slope_exp = 0;
        for (int b = 0; b < 4; b++) begin
            for (int p = 0; p < 4; p++) begin
                cfg = {2'b00, b[1], b[0]};
                host_wr(3'd0, {3'b000, cfg, 1'b0});
                pad_pin = p[0]; slope_pin = p[1];
                repeat (2) @(negedge clk);
                chk("R6 hold", pad_bypass, pad_exp);
                chk("R7 hold", slope_bypass, slope_exp);
                frame_sync = 1;
                @(negedge clk);
                pad_exp = b[0] | p[0];
                slope_exp = b[1] | p[1];
                chk("R6 sample", pad_bypass, pad_exp);
                chk("R7 sample", slope_bypass, slope_exp);
                @(negedge clk);
                frame_sync = 0;
                pad_pin = ~p[0]; slope_pin = ~p[1];
                @(negedge clk);
                chk("R6 level no edge", pad_bypass, pad_exp);
                chk("R7 level no edge", slope_bypass, slope_exp);
            end
        end
        pad_pin = 0; slope_pin = 0;

        // R8 R9 noise select during initialization
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [1:0] code;
                host_wr(3'd0, {3'b000, c[1], c[0], 2'b00, 1'b0});
                nc_pin = p[0];
                @(negedge clk);
                code = {c[1], c[0] | p[0]};
                chk("R8 through init", nc_through, code == 2'b00);
                chk("R9 att follows", nc_att, code);
            end
        end

        // R9 freeze at release, R8 live afterwards
        host_wr(3'd0, 8'h10);
        nc_pin = 0;
        @(negedge clk);
        chk("R9 pre-release", nc_att, 2'b10);
        init_mode = 0;
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [1:0] code;
                host_wr(3'd0, {3'b000, c[1], c[0], 2'b00, 1'b0});
                nc_pin = p[0];
                @(negedge clk);
                code = {c[1], c[0] | p[0]};
                chk("R8 through live", nc_through, code == 2'b00);
                chk("R9 frozen", nc_att, 2'b10);
            end
        end
        nc_pin = 0;
        init_mode = 1;
        do_reset();
        chk("R9 reset clears", nc_att, 0);
        chk("R1 through after reset", nc_through, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule